// File: doc/BRIEF.md
# Snooping MESI Write-Back Cache Controller

This block is a small direct-mapped write-back cache with one data word per line. Each line keeps a four-state coherence tag: Invalid, Shared, Exclusive or Modified. On one side it serves a CPU. On the other side it uses a shared bus to memory that other caches also watch. When the CPU touches a line, the controller either answers from the local copy or runs the bus transactions that coherence requires. When another cache puts an address on the bus, the controller updates its own copy of that line and gives a snoop response.

The CPU side follows a valid/ready rule. The CPU raises `cpu_valid` and holds `cpu_we`, `cpu_addr` and `cpu_wdata` stable until it sees `cpu_ready`. In that same cycle `cpu_rdata` carries the read result. The bus request side follows the same rule in the other direction. Once `bus_valid` is raised, command, address and write data stay fixed until `bus_ready`. Memory returns `bus_rdata`, `bus_shared_in` and `bus_retry_in` in the `bus_ready` cycle. Snoops are single-cycle, with no back-pressure, and arrive only while this controller has no bus request open, because the bus carries one transaction at a time. The responses `snp_shared` and `snp_retry` are valid in the snoop cycle.

Address bits `[IDX_W-1:0]` select the line and the upper bits form the tag. Line states are encoded I=0, S=1, E=2, M=3.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready`, `bus_valid`, `snp_shared` and `snp_retry` are low, and the first access to any address goes to the bus.
- R2: A CPU read whose tag matches a line in M, E or S raises `cpu_ready` in the cycle the request is presented, returns the stored word and starts no bus transaction.
- R3: A CPU read miss issues a read (bus_cmd 1) of `cpu_addr`. The line fills in Exclusive if `bus_shared_in` is low in the `bus_ready` cycle and in Shared otherwise. `cpu_ready` rises in the cycle after `bus_ready` and stays low while a bus request is open.
- R4: A CPU write that matches a line in E or M completes in the cycle it is presented, with no bus transaction. The line ends Modified and holds the written word.
- R5: A CPU write to an Invalid, mismatched or Shared line first issues a read-for-ownership (bus_cmd 2) of `cpu_addr`. It then completes, and the line ends Modified and holds the written word.
- R6: A miss whose victim line is Modified with a different tag writes that line back (bus_cmd 3, old address, old word) before the fetch. A victim that is not Modified is dropped with no bus transaction.
- R7: A snooped read (snp_cmd 1) that matches a valid line raises `snp_shared` in that cycle. A matching Exclusive line becomes Shared.
- R8: A snooped read-for-ownership (snp_cmd 2) or invalidate (snp_cmd 3) that matches a Shared or Exclusive line makes it Invalid without raising `snp_retry`.
- R9: A snoop that matches a Modified line raises `snp_retry` in that cycle. In the next cycle the controller writes the line back to `snp_addr`. The line then ends Shared after a snooped read and Invalid otherwise.
- R10: A snoop wins over a CPU request in the same cycle: `cpu_ready` stays low while `snp_valid` is high.
- R11: A read or read-for-ownership that completes with `bus_retry_in` high leaves the line unchanged. `bus_valid` drops for one cycle and the same request is then issued again.
- R12: A Shared line is never promoted to Exclusive. A write to a Shared line always needs a read-for-ownership, even when no other cache has responded.
- R13: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_cmd` and `bus_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write word |
| cpu_ready | output | 1 | CPU request finishes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| bus_valid | output | 1 | Bus request open |
| bus_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | ADDR_W | Bus request address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_ready | input | 1 | Bus request finishes this cycle |
| bus_rdata | input | DATA_W | Fetched word, valid with bus_ready |
| bus_shared_in | input | 1 | Another cache holds the fetched line |
| bus_retry_in | input | 1 | Request was backed off, reissue |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | 1 read, 2 read-for-ownership, 3 invalidate |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped read line |
| snp_retry | output | 1 | Requester must back off (dirty copy here) |

## Verification
A line left in the wrong coherence state does not show up at once. It shows up at the next access to that line. A line wrongly left Exclusive or Modified lets a write finish with no read-for-ownership on the bus. A line wrongly left Shared or Invalid causes an extra fetch. A stale Modified line shows up as a missing or extra write-back, or as a `snp_retry` at the next snoop. The bench therefore follows each state-changing event with a CPU access or a snoop to the same line. It also compares every bus transaction, in order, against the expected command, address and write-back word.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RFO = 2'd2, BC_WB = 2'd3} bus_cmd_t;
  typedef enum logic [1:0] {SC_NONE = 2'd0, SC_RD = 2'd1, SC_RFO = 2'd2, SC_INV = 2'd3} snp_cmd_t;
  typedef enum logic [1:0] {C_IDLE = 2'd0, C_EVICT = 2'd1, C_FETCH = 2'd2, C_SWB = 2'd3} ctl_st_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_t          wr_state,
  input  logic              wr_fill,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= ST_I;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        st_q[g] <= wr_state;
        if (wr_fill) begin
          tag_q[g]  <= wr_tag;
          data_q[g] <= wr_data;
        end
      end
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = data_q[b_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             active,
  input  snp_cmd_t         cmd,
  input  logic [TAG_W-1:0] tag,
  input  line_st_t         line_state,
  input  logic [TAG_W-1:0] line_tag,
  output logic             shared,
  output logic             retry,
  output logic             upd,
  output line_st_t         nxt_state,
  output logic             wb_inv
);
  logic hit;

  always_comb begin
    hit       = active && (cmd != SC_NONE) && (line_state != ST_I) && (line_tag == tag);
    shared    = hit && (cmd == SC_RD);
    retry     = hit && (line_state == ST_M);
    upd       = hit && (line_state != ST_M);
    wb_inv    = (cmd != SC_RD);
    nxt_state = (cmd == SC_RD) ? ST_S : ST_I;
  end
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              bus_retry_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_retry
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_st_t           st_q, st_d;
  logic [IDX_W-1:0]  swb_idx_q;
  logic              swb_inv_q;

  logic [IDX_W-1:0]  cpu_idx, snp_idx, b_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  line_st_t          a_state, b_state;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic              wr_en, wr_fill;
  logic [IDX_W-1:0]  wr_idx;
  line_st_t          wr_state;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  logic              sr_upd, sr_wb_inv;
  line_st_t          sr_nxt;
  bus_cmd_t          bcmd;

  logic idle, cpu_go, cpu_match, rd_hit, wr_hit, need_evict;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
  assign b_idx   = (st_q == C_SWB) ? swb_idx_q : snp_idx;

  mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cpu_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state), .wr_fill(wr_fill),
    .wr_tag(wr_tag), .wr_data(wr_data)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .active(idle && snp_valid), .cmd(snp_cmd_t'(snp_cmd)), .tag(snp_tag),
    .line_state(b_state), .line_tag(b_tag),
    .shared(snp_shared), .retry(snp_retry), .upd(sr_upd),
    .nxt_state(sr_nxt), .wb_inv(sr_wb_inv)
  );

  assign idle       = (st_q == C_IDLE);
  assign cpu_go     = idle && cpu_valid && !snp_valid;
  assign cpu_match  = (a_state != ST_I) && (a_tag == cpu_tag);
  assign rd_hit     = !cpu_we && cpu_match;
  assign wr_hit     = cpu_we && cpu_match && (a_state == ST_E || a_state == ST_M);
  assign need_evict = (a_state == ST_M) && (a_tag != cpu_tag);
  assign cpu_ready  = cpu_go && (rd_hit || wr_hit);
  assign cpu_rdata  = a_data;
  assign bus_cmd    = bcmd;

  always_comb begin
    st_d      = st_q;
    wr_en     = 1'b0;
    wr_fill   = 1'b0;
    wr_idx    = cpu_idx;
    wr_state  = ST_I;
    wr_tag    = cpu_tag;
    wr_data   = cpu_wdata;
    bus_valid = 1'b0;
    bcmd      = BC_NONE;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (st_q)
      C_IDLE: begin
        if (snp_retry) begin
          st_d = C_SWB;
        end else if (sr_upd) begin
          wr_en    = 1'b1;
          wr_idx   = snp_idx;
          wr_state = sr_nxt;
        end else if (cpu_go) begin
          if (wr_hit) begin
            wr_en    = 1'b1;
            wr_fill  = 1'b1;
            wr_state = ST_M;
          end else if (!rd_hit) begin
            st_d = need_evict ? C_EVICT : C_FETCH;
          end
        end
      end
      C_EVICT: begin
        bus_valid = 1'b1;
        bcmd      = BC_WB;
        bus_addr  = {a_tag, cpu_idx};
        bus_wdata = a_data;
        if (bus_ready) begin
          wr_en    = 1'b1;
          wr_state = ST_I;
          st_d     = C_FETCH;
        end
      end
      C_FETCH: begin
        bus_valid = 1'b1;
        bcmd      = cpu_we ? BC_RFO : BC_RD;
        bus_addr  = cpu_addr;
        if (bus_ready) begin
          st_d = C_IDLE;
          if (!bus_retry_in) begin
            wr_en    = 1'b1;
            wr_fill  = 1'b1;
            wr_data  = bus_rdata;
            wr_state = cpu_we ? ST_M : (bus_shared_in ? ST_S : ST_E);
          end
        end
      end
      C_SWB: begin
        bus_valid = 1'b1;
        bcmd      = BC_WB;
        bus_addr  = {b_tag, swb_idx_q};
        bus_wdata = b_data;
        if (bus_ready) begin
          wr_en    = 1'b1;
          wr_idx   = swb_idx_q;
          wr_state = swb_inv_q ? ST_I : ST_S;
          st_d     = C_IDLE;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= C_IDLE;
      swb_idx_q <= '0;
      swb_inv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (snp_retry) begin
        swb_idx_q <= snp_idx;
        swb_inv_q <= sr_wb_inv;
      end
    end
  end
endmodule

// File: rtl/mesi_cache_ctrl_chk.sv
module mesi_cache_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_retry,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_retry_in
);
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_cmd) && $stable(bus_addr)); // R13
  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready); // R10
  AST_CPU_WAITS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !cpu_ready); // R3
  AST_BACKOFF_WB: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |=> bus_valid && bus_cmd == 2'd3 && bus_addr == $past(snp_addr)); // R9
  AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_retry_in && bus_cmd != 2'd3 |=> !bus_valid); // R11
endmodule

bind mesi_cache_ctrl mesi_cache_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .snp_valid(snp_valid),
  .snp_addr(snp_addr), .snp_retry(snp_retry), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_retry_in(bus_retry_in)
);

// File: tb/tb_mesi_cache_ctrl.sv
module tb_mesi_cache_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_valid;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ready = 0, bus_shared_in = 0, bus_retry_in = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_retry;

  always #2 clk = ~clk;

  mesi_cache_ctrl #(.LINES(4), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

  typedef struct packed {logic [1:0] cmd; logic [AW-1:0] addr; logic [DW-1:0] data;} bus_item_t;
  bus_item_t exp_q[$];
  logic [DW-1:0] mem [256];
  int checks = 0, fails = 0;
  bit retry_once = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_bus(logic [1:0] c, logic [AW-1:0] a, logic [DW-1:0] d);
    bus_item_t it;
    it.cmd = c; it.addr = a; it.data = d;
    exp_q.push_back(it);
  endtask

  // memory responder and bus scoreboard monitor
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + DW'(i);
    forever begin
      @(negedge clk);
      if (bus_ready) begin
        bus_ready = 0;
        bus_retry_in = 0;
      end else if (bus_valid && rst_n) begin
        bus_item_t e;
        if (exp_q.size() == 0) begin
          chk(0, "R6", "unexpected bus cmd/addr", {bus_cmd, bus_addr}, 0);
        end else begin
          e = exp_q.pop_front();
          chk(bus_cmd == e.cmd && bus_addr == e.addr, "R6", "bus cmd/addr",
              {bus_cmd, bus_addr}, {e.cmd, e.addr});
          if (e.cmd == 2'd3)
            chk(bus_wdata == e.data, "R6", "write-back word", bus_wdata, e.data);
        end
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
        bus_rdata = mem[bus_addr];
        if (retry_once && bus_cmd != 2'd3) begin
          bus_retry_in = 1;
          retry_once = 0;
        end
        bus_ready = 1;
      end
    end
  end

  task automatic drain(string req);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, req, "pending bus items", exp_q.size(), 0);
  endtask

  task automatic cpu_op(bit we, logic [AW-1:0] a, logic [DW-1:0] wd, logic [DW-1:0] exp_rd, string req);
    int n = 0;
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    while (!cpu_ready && n < 60) begin
      @(negedge clk); #1; n++;
    end
    chk(cpu_ready, req, "cpu_ready", cpu_ready, 1);
    if (!we) chk(cpu_rdata == exp_rd, req, "cpu_rdata", cpu_rdata, exp_rd);
    @(negedge clk);
    cpu_valid = 0; cpu_we = 0;
    chk(exp_q.size() == 0, req, "bus items left after cpu op", exp_q.size(), 0);
  endtask

  task automatic snoop(logic [1:0] c, logic [AW-1:0] a, bit e_sh, bit e_rt, string req);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1;
    chk(snp_shared == e_sh, req, "snp_shared", snp_shared, e_sh);
    chk(snp_retry == e_rt, req, "snp_retry", snp_retry, e_rt);
    @(negedge clk);
    snp_valid = 0; snp_cmd = 0;
    drain(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!cpu_ready && !bus_valid && !snp_shared && !snp_retry, "R1", "outputs in reset",
        {cpu_ready, bus_valid, snp_shared, snp_retry}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!cpu_ready && !bus_valid, "R1", "idle after reset", {cpu_ready, bus_valid}, 0);

    // R1/R3: first read misses, fills Exclusive; R4: write hit with no bus; R2: read hit
    bus_shared_in = 0;
    expect_bus(2'd1, 8'h10, '0);
    cpu_op(0, 8'h10, '0, 16'hA010, "R3");
    cpu_op(1, 8'h10, 16'h1111, '0, "R4");
    cpu_op(0, 8'h10, '0, 16'h1111, "R2");

    // R6: Modified victim written back before fetch
    expect_bus(2'd3, 8'h10, 16'h1111);
    expect_bus(2'd1, 8'h20, '0);
    cpu_op(0, 8'h20, '0, 16'hA020, "R6");

    // R12/R5: shared fill, write needs RFO
    bus_shared_in = 1;
    expect_bus(2'd1, 8'h21, '0);
    cpu_op(0, 8'h21, '0, 16'hA021, "R3");
    expect_bus(2'd2, 8'h21, '0);
    cpu_op(1, 8'h21, 16'h2222, '0, "R12");
    cpu_op(0, 8'h21, '0, 16'h2222, "R5");

    // R6: M victim written back; then S victim dropped silently
    expect_bus(2'd3, 8'h21, 16'h2222);
    expect_bus(2'd1, 8'h25, '0);
    cpu_op(0, 8'h25, '0, 16'hA025, "R6");
    bus_shared_in = 0;
    expect_bus(2'd1, 8'h29, '0);
    cpu_op(0, 8'h29, '0, 16'hA029, "R6");

    // R7: snooped read on Exclusive -> Shared, so next write needs RFO
    snoop(2'd1, 8'h29, 1, 0, "R7");
    expect_bus(2'd2, 8'h29, '0);
    cpu_op(1, 8'h29, 16'h3333, '0, "R7");

    // R9: snooped read on Modified -> retry, write-back, Shared
    expect_bus(2'd3, 8'h29, 16'h3333);
    snoop(2'd1, 8'h29, 1, 1, "R9");
    cpu_op(0, 8'h29, '0, 16'h3333, "R9");
    expect_bus(2'd2, 8'h29, '0);
    cpu_op(1, 8'h29, 16'h4444, '0, "R9");
    expect_bus(2'd3, 8'h29, 16'h4444);
    snoop(2'd2, 8'h29, 0, 1, "R9");
    expect_bus(2'd1, 8'h29, '0);
    cpu_op(0, 8'h29, '0, 16'h4444, "R9");

    // R8: invalidate on Shared, RFO on Exclusive
    bus_shared_in = 1;
    expect_bus(2'd1, 8'h2A, '0);
    cpu_op(0, 8'h2A, '0, 16'hA02A, "R8");
    snoop(2'd3, 8'h2A, 0, 0, "R8");
    bus_shared_in = 0;
    expect_bus(2'd1, 8'h2A, '0);
    cpu_op(0, 8'h2A, '0, 16'hA02A, "R8");
    snoop(2'd2, 8'h2A, 0, 0, "R8");
    bus_shared_in = 1;
    expect_bus(2'd1, 8'h2A, '0);
    cpu_op(0, 8'h2A, '0, 16'hA02A, "R8");
    bus_shared_in = 0;

    // R11: backed-off fetch is reissued
    retry_once = 1;
    expect_bus(2'd1, 8'h33, '0);
    expect_bus(2'd1, 8'h33, '0);
    cpu_op(0, 8'h33, '0, 16'hA033, "R11");

    // R7: snoop miss gives no shared response
    snoop(2'd1, 8'h3F, 0, 0, "R7");

    // R5: write miss over a clean victim issues only RFO
    expect_bus(2'd2, 8'h14, '0);
    cpu_op(1, 8'h14, 16'hBEEF, '0, "R5");
    cpu_op(0, 8'h14, '0, 16'hBEEF, "R5");

    // R10: snoop and CPU in the same cycle
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_addr = 8'h14;
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h3F;
    #1;
    chk(!cpu_ready, "R10", "cpu_ready under snoop", cpu_ready, 0);
    @(negedge clk);
    snp_valid = 0; snp_cmd = 0;
    #1;
    chk(cpu_ready && cpu_rdata == 16'hBEEF, "R10", "cpu after snoop", cpu_rdata, 16'hBEEF);
    @(negedge clk);
    cpu_valid = 0;
    drain("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule